// File: doc/BRIEF.md
# Counted-Cycle Digital Lock Detector

This block decides whether a phase-locked loop has settled by looking at the pulses its phase-frequency detector sends toward the charge pump. For each comparison period it counts how many ticks of a fast sampling clock either correction pulse was active, and treats that count as the phase error of that period. A strobe marks the end of each period, and the count is judged at that moment.

The detector has hysteresis. A tight threshold admits a period as good. A run of good periods, three or five long, raises the lock flag. Once the flag is up, it drops only when a single period exceeds a looser threshold. An output enable follows the flag when muting is requested, so that a radio output stays quiet until the loop has settled. A power-down input clears the whole lock state.

Top module: `pfd_lock_monitor`

## Requirements
- R1: The phase error of a period is the number of sampling-clock cycles in which `up_i` or `dn_i` was high since the previous `ref_tick`. A period is good when that count is below LOCK_CNT (LOCK_PS/SAMPLE_PS, 15 by default).
- R2: With `prec_sel` = 0, and while unlocked, `lock_o` rises on the clock edge that samples the third consecutive good `ref_tick`.
- R3: With `prec_sel` = 1, five consecutive good periods are required before `lock_o` rises.
- R4: While locked, a period whose count exceeds UNLOCK_CNT (UNLOCK_PS/SAMPLE_PS, 25 by default) clears `lock_o` on the edge that samples its `ref_tick`. A count of exactly UNLOCK_CNT leaves the flag set.
- R5: While locked, a period that is not above UNLOCK_CNT leaves `lock_o` unchanged. While unlocked, any period that is not good, including one of exactly LOCK_CNT, restarts the consecutive count from zero.
- R6: While `pwr_down` is high, `lock_o` and `out_en_o` are low, and the run of good periods collected so far is discarded.
- R7: With `mute_en` = 1, `out_en_o` equals `lock_o`. With `mute_en` = 0, `out_en_o` is high whenever the block is not powered down.
- R8: The error count saturates above UNLOCK_CNT, so a pulse of any length, however long, is judged a bad period and never wraps to a small count.
- R9: Up pulses and down pulses are measured alike, and a down-only period is judged the same as an up-only period of equal width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock that measures the pulse widths |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Power-down; clears the lock state while high |
| up_i | input | 1 | Detector pulse that pushes the frequency up |
| dn_i | input | 1 | Detector pulse that pushes the frequency down |
| ref_tick | input | 1 | One-cycle strobe that ends a comparison period |
| prec_sel | input | 1 | 0: three good periods lock; 1: five |
| mute_en | input | 1 | Hold the output enable low until lock |
| lock_o | output | 1 | Active-high lock flag |
| out_en_o | output | 1 | Gated output enable |

## Verification
The bench aims at the threshold edges. A width of exactly 15 counts must break a run, and a width of exactly 25 counts must not unlock. An off-by-one comparison would lock too early there, or drop lock on a harmless period. A mid-range width is tried on both sides of lock: it must hold an existing lock yet restart a run that has not yet locked. A design without hysteresis would unlock on it, and one that ignored it while unlocked would lock after too few consecutive periods. Power-down in the middle of a run, the five-period setting, down-only pulses, and a pulse long enough to wrap a non-saturating counter are each aimed at one specific miscount.

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor #(
  parameter int SAMPLE_PS = 1000,
  parameter int LOCK_PS   = 15000,
  parameter int UNLOCK_PS = 25000,
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic up_i,
  input  logic dn_i,
  input  logic ref_tick,
  input  logic prec_sel,
  input  logic mute_en,
  output logic lock_o,
  output logic out_en_o
);
  localparam int LOCK_CNT   = LOCK_PS / SAMPLE_PS;
  localparam int UNLOCK_CNT = UNLOCK_PS / SAMPLE_PS;
  localparam int SAT_CNT    = UNLOCK_CNT + 1;
  localparam int CW         = $clog2(SAT_CNT + 1);
  localparam int RW         = $clog2(LONG_RUN + 1);

  logic [CW-1:0] width_q;
  logic [RW-1:0] run_q;
  logic          lock_q;

  wire          phase_err = up_i | dn_i;
  wire          good      = width_q < CW'(LOCK_CNT);
  wire          bad       = width_q > CW'(UNLOCK_CNT);
  wire [RW-1:0] need      = prec_sel ? RW'(LONG_RUN) : RW'(SHORT_RUN);
  wire [RW-1:0] run_nx    = run_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_down) begin
      width_q <= '0;
      run_q   <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (ref_tick)
        width_q <= {{(CW-1){1'b0}}, phase_err};
      else if (phase_err && width_q != CW'(SAT_CNT))
        width_q <= width_q + 1'b1;

      if (ref_tick) begin
        if (lock_q) begin
          if (bad) begin
            lock_q <= 1'b0;
            run_q  <= '0;
          end
        end else if (good) begin
          if (run_nx >= need) begin
            lock_q <= 1'b1;
            run_q  <= '0;
          end else begin
            run_q <= run_nx;
          end
        end else begin
          run_q <= '0;
        end
      end
    end
  end

  assign lock_o   = lock_q;
  assign out_en_o = !pwr_down && (!mute_en || lock_q);

  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(ref_tick));
  a_r4_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> ($past(ref_tick) || $past(pwr_down)));
  a_r5_hold_lock: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
    (lock_o && !ref_tick) |=> lock_o);
  a_r6_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !lock_o);
  a_r7_muted: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_en && !lock_o) |-> !out_en_o);
  a_r3_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RW'(LONG_RUN));
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
    (phase_err && !ref_tick && width_q == CW'(SAT_CNT)) |=> width_q == CW'(SAT_CNT));
endmodule

// File: tb/pfd_lock_monitor_tb.sv
module pfd_lock_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_down = 1'b0, up_i = 1'b0, dn_i = 1'b0;
  logic ref_tick = 1'b0, prec_sel = 1'b0, mute_en = 1'b0;
  logic lock_o, out_en_o;
  int   n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pfd_lock_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .up_i(up_i), .dn_i(dn_i),
    .ref_tick(ref_tick), .prec_sel(prec_sel), .mute_en(mute_en),
    .lock_o(lock_o), .out_en_o(out_en_o));

  // {width[7:0], prec_sel, use_dn, expected lock}
  localparam logic [10:0] VEC [17] = '{
    {8'd5,  1'b0, 1'b0, 1'b0},   // R2 first good
    {8'd5,  1'b0, 1'b1, 1'b0},   // R9 down pulse counts as good
    {8'd5,  1'b0, 1'b0, 1'b1},   // R2 third good locks
    {8'd20, 1'b0, 1'b0, 1'b1},   // R5 mid-range holds
    {8'd25, 1'b0, 1'b0, 1'b1},   // R4 exactly 25 holds
    {8'd30, 1'b0, 1'b1, 1'b0},   // R4 R9 large down error unlocks
    {8'd14, 1'b0, 1'b0, 1'b0},   // R1 14 is good
    {8'd15, 1'b0, 1'b0, 1'b0},   // R5 exactly 15 restarts run
    {8'd14, 1'b0, 1'b0, 1'b0},
    {8'd14, 1'b0, 1'b0, 1'b0},
    {8'd14, 1'b0, 1'b1, 1'b1},   // R2 locks after restart
    {8'd26, 1'b0, 1'b0, 1'b0},   // R4 26 unlocks
    {8'd10, 1'b1, 1'b0, 1'b0},   // R3
    {8'd10, 1'b1, 1'b0, 1'b0},
    {8'd10, 1'b1, 1'b0, 1'b0},
    {8'd10, 1'b1, 1'b0, 1'b0},
    {8'd10, 1'b1, 1'b0, 1'b1}    // R3 fifth good locks
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic period(input int width, input logic use_dn);
    if (width > 0) begin
      up_i = !use_dn;
      dn_i = use_dn;
      repeat (width) @(negedge clk);
      up_i = 1'b0;
      dn_i = 1'b0;
    end
    repeat (2) @(negedge clk);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset lock", lock_o, 1'b0);
    chk("R7 unmuted enable in reset", out_en_o, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 17; i++) begin
      prec_sel = VEC[i][2];
      period(int'(VEC[i][10:3]), VEC[i][1]);
      chk($sformatf("R1-table entry %0d (R2 R3 R4 R5 R9)", i), lock_o, VEC[i][0]);
    end

    // R6 power-down while locked
    pwr_down = 1'b1;
    @(negedge clk);
    chk("R6 lock cleared", lock_o, 1'b0);
    chk("R6 enable low", out_en_o, 1'b0);
    pwr_down = 1'b0;
    @(negedge clk);

    // R6 run discarded by power-down
    prec_sel = 1'b0;
    period(5, 1'b0);
    period(5, 1'b0);
    pwr_down = 1'b1;
    @(negedge clk);
    pwr_down = 1'b0;
    @(negedge clk);
    period(5, 1'b0);
    chk("R6 run restarted after power-down", lock_o, 1'b0);
    period(5, 1'b0);
    chk("R6 second after power-down", lock_o, 1'b0);

    // R7 mute until lock
    mute_en = 1'b1;
    @(negedge clk);
    chk("R7 muted before lock", out_en_o, 1'b0);
    period(5, 1'b0);
    chk("R7 lock reached", lock_o, 1'b1);
    chk("R7 enabled after lock", out_en_o, 1'b1);

    // R8 very long pulse
    period(200, 1'b0);
    chk("R8 saturated width unlocks", lock_o, 1'b0);
    chk("R7 muted again", out_en_o, 1'b0);

    // R5 mid-range breaks a run while unlocked
    period(5, 1'b0);
    period(5, 1'b0);
    period(20, 1'b0);
    period(5, 1'b0);
    period(5, 1'b0);
    chk("R5 mid-range restarted run", lock_o, 1'b0);
    period(5, 1'b0);
    chk("R5 lock after restart", lock_o, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule